// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It divides the input clock by a power-of-two factor to form a converter clock, and every output changes only on that converter clock. Each conversion has three phases. First the track output is held high for a programmable number of converter clocks while the sampling capacitor follows the input. Then the hold output is raised and an N-bit result is resolved by binary search, one bit per converter clock, starting from the most significant bit. Last comes a one-clock end-of-conversion pulse while the front end returns to tracking.

During the search the trial code goes to an external DAC. A single comparator bit comes back: it is 1 when the held input is at or above the trial code. A channel mask selects up to eight inputs. These are visited in ascending order with wraparound through a channel-select output, so with K channels enabled each channel is refreshed at 1/K of the conversion rate. In continuous mode conversions follow one another without a gap. In single mode one result is produced per start request.

Top module: `sar_seq`

## Requirements
- R1: A synchronous reset clears track, hold, eoc, dac_code, result and result_ch to zero, sets ch_sel to NCH-1 and leaves the block idle.
- R2: The converter clock is the input clock divided by 2**prescale_sel. Values above 6 give a divisor of 64. Outputs change only at converter clock boundaries.
- R3: The result is resolved MSB first. Each step sets the trial bit in dac_code and keeps it when cmp_in is 1 (input >= code) or clears it when cmp_in is 0. dac_code is zero whenever hold is low.
- R4: Each conversion starts with track high for sample_len converter clocks. A sample_len of 0 counts as 1.
- R5: hold rises as track falls and stays high for exactly NBITS converter clocks. track and hold are never high together.
- R6: eoc is high for exactly one converter clock after the last bit is decided. result and result_ch take their new values at the rising edge of eoc and stay stable at all other times.
- R7: Each conversion uses the next channel enabled in ch_mask after the current ch_sel, ascending with wraparound. ch_sel is constant for the whole conversion, so the first conversion after reset uses the lowest enabled channel.
- R8: In continuous mode the eoc rising edges are (max(sample_len,1) + NBITS + 1) × divisor input clocks apart.
- R9: In single mode one start yields exactly one result. A start that arrives during a conversion is queued and yields one more result. A start with an all-zero ch_mask yields none.
- R10: When continuous is cleared, the block finishes the current conversion and then goes idle with no further eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, one cycle or longer |
| continuous | input | 1 | 1: convert back to back, 0: one result per request |
| prescale_sel | input | 3 | Clock divisor exponent (divisor 2**value, capped at 64) |
| sample_len | input | 8 | Track length in converter clocks (0 treated as 1) |
| ch_mask | input | 8 | Enabled channels, bit i enables channel i |
| cmp_in | input | 1 | Comparator: 1 when the held input >= dac_code |
| dac_code | output | 12 | Trial code for the external DAC |
| track | output | 1 | Sampling capacitor follows the input |
| hold | output | 1 | Sampled value held during bit decisions |
| ch_sel | output | 3 | Channel being converted |
| eoc | output | 1 | End-of-conversion pulse, usable as an interrupt |
| result | output | 12 | Last completed conversion result |
| result_ch | output | 3 | Channel of the last completed result |

## Verification
The bench drives the comparator from a per-channel input value and tests full-scale and zero inputs. A design that mishandled the first or last bit would return 4095 or 0 wrongly, or leave dac_code non-zero outside hold. It runs a sparse channel mask across the wrap point. Skipped or repeated channels would show up in the recorded result_ch sequence, and so would a scan that restarted from channel 0. A zero sample length and a prescaler code above the largest divisor are both used. A design without the minimum-one rule or without the cap would stretch or shrink the measured eoc period and eoc width. A second start arriving during a single-mode conversion must add exactly one result. A start with an empty mask must add none. Clearing continuous mode must let the running conversion finish and then stop.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 12,
  parameter int NCH   = 8,
  parameter int SLW   = 8,
  parameter int PSMAX = 6,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SELW = $clog2(PSMAX + 1),
  localparam int PCW  = (PSMAX > 0) ? PSMAX : 1,
  localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             continuous,
  input  logic [SELW-1:0]  prescale_sel,
  input  logic [SLW-1:0]   sample_len,
  input  logic [NCH-1:0]   ch_mask,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic             track,
  output logic             hold,
  output logic [CHW-1:0]   ch_sel,
  output logic             eoc,
  output logic [NBITS-1:0] result,
  output logic [CHW-1:0]   result_ch
);
  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_CONV, S_EOC} st_t;
  st_t st;

  logic [PCW-1:0]   pcnt, div_m1;
  logic [SELW-1:0]  sel_c;
  logic [SLW-1:0]   scnt, len_m1;
  logic [BW-1:0]    bi;
  logic [NBITS-1:0] trial;
  logic [CHW-1:0]   nxt_ch;
  logic             req, tick, go, any_en;

  assign sel_c  = (prescale_sel > SELW'(PSMAX)) ? SELW'(PSMAX) : prescale_sel;
  assign div_m1 = PCW'((1 << sel_c) - 1);
  assign tick   = (pcnt >= div_m1);
  assign len_m1 = (sample_len == '0) ? '0 : sample_len - 1'b1;
  assign go     = req | start;
  assign any_en = |ch_mask;

  always_comb begin
    trial     = dac_code;
    trial[bi] = cmp_in;
  end

  always_comb begin
    nxt_ch = ch_sel;
    for (int k = NCH; k >= 1; k--)
      if (ch_mask[(int'(ch_sel) + k) % NCH]) nxt_ch = CHW'((int'(ch_sel) + k) % NCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pcnt      <= '0;
      scnt      <= '0;
      bi        <= '0;
      req       <= 1'b0;
      track     <= 1'b0;
      hold      <= 1'b0;
      eoc       <= 1'b0;
      dac_code  <= '0;
      result    <= '0;
      result_ch <= '0;
      ch_sel    <= CHW'(NCH - 1);
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (start) req <= 1'b1;
      if (tick) begin
        eoc <= 1'b0;
        unique case (st)
          S_IDLE: begin
            req <= 1'b0;
            if (go && any_en) begin
              st     <= S_TRACK;
              track  <= 1'b1;
              scnt   <= '0;
              ch_sel <= nxt_ch;
            end
          end
          S_TRACK: begin
            if (scnt >= len_m1) begin
              st       <= S_CONV;
              track    <= 1'b0;
              hold     <= 1'b1;
              dac_code <= {1'b1, {(NBITS-1){1'b0}}};
              bi       <= BW'(NBITS - 1);
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          S_CONV: begin
            if (bi == '0) begin
              st        <= S_EOC;
              hold      <= 1'b0;
              eoc       <= 1'b1;
              result    <= trial;
              result_ch <= ch_sel;
              dac_code  <= '0;
            end else begin
              dac_code <= trial | (NBITS'(1) << (bi - 1'b1));
              bi       <= bi - 1'b1;
            end
          end
          S_EOC: begin
            req <= 1'b0;
            if (any_en && (continuous || go)) begin
              st     <= S_TRACK;
              track  <= 1'b1;
              scnt   <= '0;
              ch_sel <= nxt_ch;
            end else begin
              st <= S_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

module sar_seq_chk #(
  parameter int NBITS = 12,
  parameter int CHW   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             track,
  input logic             hold,
  input logic             eoc,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-1:0] result,
  input logic [CHW-1:0]   ch_sel
);
  // R5
  track_hold_excl_chk: assert property (@(posedge clk) disable iff (rst) !(track && hold));
  // R3
  dac_idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !hold |-> dac_code == '0);
  // R6
  result_update_chk: assert property (@(posedge clk) disable iff (rst) !$stable(result) |-> $rose(eoc));
  // R6
  eoc_after_hold_chk: assert property (@(posedge clk) disable iff (rst) $rose(eoc) |-> $past(hold));
  // R4
  hold_after_track_chk: assert property (@(posedge clk) disable iff (rst) $rose(hold) |-> $past(track));
  // R7
  ch_steady_chk: assert property (@(posedge clk) disable iff (rst) hold |-> $stable(ch_sel));
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS), .CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .track(track), .hold(hold), .eoc(eoc),
  .dac_code(dac_code), .result(result), .ch_sel(ch_sel)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  localparam int N = 12;
  localparam int NCH = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, continuous = 1'b0, cmp_in;
  logic [2:0] prescale_sel = '0;
  logic [7:0] sample_len = 8'd5, ch_mask = '0;
  logic [N-1:0] dac_code, result;
  logic track, hold, eoc;
  logic [2:0] ch_sel, result_ch;
  logic [N-1:0] ain [NCH];

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  always #10 clk = ~clk;

  assign cmp_in = (ain[ch_sel] >= dac_code);

  sar_seq uut (
    .clk(clk), .rst(rst), .start(start), .continuous(continuous),
    .prescale_sel(prescale_sel), .sample_len(sample_len), .ch_mask(ch_mask),
    .cmp_in(cmp_in), .dac_code(dac_code), .track(track), .hold(hold),
    .ch_sel(ch_sel), .eoc(eoc), .result(result), .result_ch(result_ch)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 track, 2 decide, 3 end pulse
  int m_st, m_pc, m_sc, m_b, m_code, m_res, m_rch, m_ch;
  bit m_req, m_eoc, m_track, m_hold;

  task automatic begin_conv();
    for (int k = 1; k <= NCH; k++) begin
      if (ch_mask[(m_ch + k) % NCH]) begin
        m_ch = (m_ch + k) % NCH;
        break;
      end
    end
    m_st = 1; m_sc = 0; m_track = 1;
  endtask

  always @(posedge clk) begin
    int dv, ln;
    bit tk, go;
    started = 1;
    cyc++;
    if (rst) begin
      m_st = 0; m_pc = 0; m_sc = 0; m_b = 0; m_code = 0; m_res = 0; m_rch = 0;
      m_ch = NCH - 1; m_req = 0; m_eoc = 0; m_track = 0; m_hold = 0;
    end else begin
      dv = 1 << ((prescale_sel > 6) ? 6 : prescale_sel);
      tk = (m_pc >= dv - 1);
      go = m_req || start;
      if (start) m_req = 1;
      m_pc = tk ? 0 : m_pc + 1;
      if (tk) begin
        m_eoc = 0;
        case (m_st)
          0: begin
            m_req = 0;
            if (go && ch_mask != 0) begin_conv();
          end
          1: begin
            ln = (sample_len == 0) ? 1 : sample_len;
            m_sc++;
            if (m_sc >= ln) begin
              m_st = 2; m_track = 0; m_hold = 1; m_b = N - 1; m_code = 1 << (N - 1);
            end
          end
          2: begin
            if (ain[m_ch] < m_code) m_code -= (1 << m_b);
            if (m_b == 0) begin
              m_st = 3; m_hold = 0; m_eoc = 1; m_res = m_code; m_rch = m_ch; m_code = 0;
            end else begin
              m_b--; m_code += (1 << m_b);
            end
          end
          default: begin
            m_req = 0;
            if (ch_mask != 0 && (continuous || go)) begin_conv();
            else m_st = 0;
          end
        endcase
      end
    end
  end

  // measurement of eoc edges and per-cycle comparison
  bit eoc_q = 0;
  int last_rise = -1, period = 0, cur_w = 0, width = 0;
  int chq[$];

  always @(negedge clk) begin
    if (started) begin
      chk("R4 track", track, m_track);
      chk("R5 hold", hold, m_hold);
      chk("R6 eoc", eoc, m_eoc);
      chk("R3 dac_code", dac_code, m_code);
      chk("R7 ch_sel", ch_sel, m_ch);
      chk("R3 result", result, m_res);
      chk("R6 result_ch", result_ch, m_rch);
      if (eoc && !eoc_q) begin
        if (last_rise >= 0) period = cyc - last_rise;
        last_rise = cyc;
        chq.push_back(result_ch);
      end
      if (eoc) cur_w++;
      else if (eoc_q) begin width = cur_w; cur_w = 0; end
      eoc_q = eoc;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n0;
    for (int i = 0; i < NCH; i++) ain[i] = N'(i * 517 + 101);
    ain[0] = 12'hA5C;
    wait_cyc(3);
    chk("R1 track", track, 0);
    chk("R1 hold", hold, 0);
    chk("R1 eoc", eoc, 0);
    chk("R1 result", result, 0);
    chk("R1 ch_sel", ch_sel, NCH - 1);
    @(negedge clk) rst = 1'b0;

    // continuous, single channel, divisor 1
    ch_mask = 8'b0000_0001; continuous = 1'b1; prescale_sel = 3'd0; sample_len = 8'd5;
    pulse_start();
    wait_cyc(100);
    chk("R8 period div1", period, 18);
    chk("R6 eoc width", width, 1);
    chk("R3 result ch0", result, 12'hA5C);

    // stop continuous mode
    continuous = 1'b0;
    wait_cyc(30);
    n0 = chq.size();
    wait_cyc(40);
    chk("R10 no more eoc", chq.size(), n0);
    chk("R10 idle track", track, 0);
    chk("R10 idle hold", hold, 0);

    // sparse mask, wraparound, zero sample length, divisor 4
    chq.delete(); last_rise = -1;
    ch_mask = 8'b1010_0100; prescale_sel = 3'd2; sample_len = 8'd0; continuous = 1'b1;
    pulse_start();
    wait_cyc(8 * 56);
    chk("R8 period div4 len0", period, 56);
    chk("R2 eoc width div4", width, 4);
    chk("R7 scan 1st", chq[0], 2);
    chk("R7 scan 2nd", chq[1], 5);
    chk("R7 scan 3rd", chq[2], 7);
    chk("R7 scan wrap", chq[3], 2);
    continuous = 1'b0;
    wait_cyc(120);

    // single mode with a queued start
    chq.delete();
    ch_mask = 8'b0001_0010; prescale_sel = 3'd1; sample_len = 8'd3;
    pulse_start();
    wait_cyc(120);
    chk("R9 single one result", chq.size(), 1);
    pulse_start();
    wait_cyc(10);
    pulse_start();
    wait_cyc(150);
    chk("R9 queued start", chq.size(), 3);
    chk("R7 alternate", (chq[1] != chq[2]) ? 1 : 0, 1);

    // empty mask start ignored
    ch_mask = '0;
    pulse_start();
    wait_cyc(60);
    chk("R9 empty mask", chq.size(), 3);
    chk("R9 empty mask track", track, 0);

    // saturated divisor and full-scale / zero inputs
    ch_mask = 8'b1000_0000; prescale_sel = 3'd7; sample_len = 8'd2;
    ain[7] = 12'hFFF;
    pulse_start();
    wait_cyc(1150);
    chk("R2 eoc width div64", width, 64);
    chk("R3 full scale", result, 12'hFFF);
    chk("R7 result_ch", result_ch, 7);
    ain[7] = 12'h000;
    pulse_start();
    wait_cyc(1150);
    chk("R3 zero input", result, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule